// File: doc/BRIEF.md
# Ethernet Receive Length Error Counters

This block sits beside an Ethernet receive MAC and looks at a short summary of every frame once reception of that frame is complete. The summary gives the byte length, whether the frame carried a VLAN tag, whether its frame check sequence matched, whether the length had a partial trailing byte (dribble), and whether the MAC judged the frame well formed. From that summary the block decides whether the frame was too long or too short. It counts each kind in its own 16-bit event counter.

A frame is too long when it exceeds the maximum length for its tag state. It is only counted as too long when its check sequence is good and nothing else is wrong with it. A frame is too short when it is under the minimum Ethernet length, and it is only counted as too short when its check sequence is bad. Software reads and writes the two counters over a small register bus. Each counter sits zero-extended in the low half of a 32-bit word. Each counter stops at its maximum value instead of wrapping.

Top module: `rxlen_err_cnt`

## Requirements
- R1: After reset both counters are zero and `bus_rdata` is zero.
- R2: On `frm_end`, an untagged frame (`frm_vlan`=0) longer than 1518 bytes increments the oversize counter when it qualifies under R4. Exactly 1518 bytes does not count.
- R3: On `frm_end`, a tagged frame (`frm_vlan`=1) longer than 1522 bytes increments the oversize counter when it qualifies under R4. Tagged frames of 1519 to 1522 bytes do not count.
- R4: An over-long frame increments the oversize counter only when `frm_fcs_ok`=1, `frm_wellformed`=1 and `frm_dribble`=0. Otherwise neither counter changes.
- R5: On `frm_end`, a frame shorter than 64 bytes with `frm_fcs_ok`=0 increments the fragment counter. This holds whatever the values of `frm_dribble` and `frm_wellformed`.
- R6: Neither counter changes for frames of 64 bytes up to the length limit, for short frames with a good check sequence, or in any cycle where `frm_end`=0.
- R7: A read with `bus_rd`=1 returns `{16'h0, counter}` on `bus_rdata` after the next rising edge. Address 0x0 selects the oversize counter and address 0x4 the fragment counter. Any other address reads 0. `bus_rdata` holds its value while `bus_rd`=0.
- R8: A write with `bus_wr`=1 loads `bus_wdata[15:0]` into the addressed counter and ignores bits 31:16. Writes to other addresses change nothing. A write overrides an increment of the same counter in the same cycle.
- R9: A counter at 0xFFFF stays at 0xFFFF when a further event arrives.
- R10: At most one of the two counters increments for any one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_end | input | 1 | Single-cycle strobe that marks a finished frame |
| frm_len | input | 16 | Frame length in bytes |
| frm_vlan | input | 1 | Frame carried a VLAN tag |
| frm_fcs_ok | input | 1 | Frame check sequence matched |
| frm_dribble | input | 1 | Length had a partial trailing byte |
| frm_wellformed | input | 1 | MAC found no other defect |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
A counter changes on the same rising edge that samples `frm_end` or `bus_wr`. Read data appears one rising edge after `bus_rd` is sampled, so a counter value shows at the port two edges after the event that changed it. The bench drives every input at a falling edge and, for each frame, issues its reads afterwards. It samples `bus_rdata` at the falling edge that follows the capturing rising edge, so each value is compared exactly when it is due. The length sweep covers each threshold at the limit and one byte either side, under all sixteen flag combinations.

// File: rtl/rxlen_pkg.sv
// Package: shared widths, limits and register layout of the receive
// length error counter block. Assumes byte addressing with one 32-bit
// word per counter.
package rxlen_pkg;
    localparam int LEN_W       = 16;
    localparam int CNT_W       = 16;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 4;
    localparam int ADDR_STRIDE = 4;
    localparam int NUM_CNT     = 2;
    localparam int MAX_PLAIN   = 1518;
    localparam int VLAN_EXTRA  = 4;
    localparam int MIN_LEN     = 64;

    // Counter slot order also fixes the register address order.
    typedef enum int unsigned {
        SLOT_OVR = 0,
        SLOT_FRG = 1
    } cnt_slot_e;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/rxlen_classify.sv
// Module: frame length classifier. Purely combinational: turns one
// frame summary into at most one increment request. Assumes frm_end
// is high for exactly one cycle per frame.
module rxlen_classify #(
    parameter int LEN_W      = 16,
    parameter int MAX_PLAIN  = 1518,
    parameter int VLAN_EXTRA = 4,
    parameter int MIN_LEN    = 64
) (
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_vlan,
    input  logic             frm_fcs_ok,
    input  logic             frm_dribble,
    input  logic             frm_wellformed,
    output logic             inc_ovr,
    output logic             inc_frg
);
    localparam int MAX_TAGGED = MAX_PLAIN + VLAN_EXTRA;

    logic [LEN_W-1:0] len_limit;
    logic             too_long;
    logic             too_short;
    logic             clean_frame;

    // Pick the length limit from the tag state.
    always_comb begin
        len_limit = frm_vlan ? LEN_W'(MAX_TAGGED) : LEN_W'(MAX_PLAIN);
    end

    // Compare the length against both bounds.
    always_comb begin
        too_long  = frm_len > len_limit;
        too_short = frm_len < LEN_W'(MIN_LEN);
    end

    // A frame counts as clean when the check sequence is good and nothing else is wrong.
    always_comb begin
        clean_frame = frm_fcs_ok && frm_wellformed && !frm_dribble;
    end

    // Raise the increment requests. The length ranges do not overlap.
    always_comb begin
        inc_ovr = frm_end && too_long && clean_frame;
        inc_frg = frm_end && too_short && !frm_fcs_ok;
    end
endmodule

// File: rtl/rxlen_sat_cnt.sv
// Module: saturating event counter with a load port. A load takes
// priority over an increment in the same cycle. The counter stops at
// all-ones.
module rxlen_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // Load, saturating increment, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxlen_regif.sv
// Module: register bus decoder. Turns a write into a per-counter load
// strobe and registers read data one cycle after a read request.
// Assumes the address is a byte address with a fixed stride per counter.
module rxlen_regif #(
    parameter int NUM_CNT     = 2,
    parameter int CNT_W       = 16,
    parameter int REG_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int ADDR_STRIDE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
    output logic [NUM_CNT-1:0]            ld_vec,
    output logic [REG_W-1:0]              bus_rdata
);
    logic [NUM_CNT-1:0] hit_vec;
    logic [CNT_W-1:0]   rd_val;

    // Per-counter address match and write strobe.
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_dec
        assign hit_vec[gi] = (bus_addr == ADDR_W'(gi * ADDR_STRIDE));
        assign ld_vec[gi]  = bus_wr && hit_vec[gi];
    end

    // Select the addressed counter. An unmapped address reads zero.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (hit_vec[i]) rd_val = cnt_vec[i];
        end
    end

    // Register read data, zero-extended, on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= REG_W'(rd_val);
        end
    end
endmodule

// File: rtl/rxlen_err_cnt.sv
// Module: top of the receive length error counter block. Classifies
// each finished frame as oversize or fragment and keeps one saturating
// counter per kind, accessible over a simple register bus.
module rxlen_err_cnt
    import rxlen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_end,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_vlan,
    input  logic              frm_fcs_ok,
    input  logic              frm_dribble,
    input  logic              frm_wellformed,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata
);
    logic                          inc_ovr;
    logic                          inc_frg;
    logic [NUM_CNT-1:0]            inc_vec;
    logic [NUM_CNT-1:0]            ld_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
    cnt_t                          cnt_ovr;
    cnt_t                          cnt_frg;
    logic                          wdata_hi_unused;

    // The reserved upper write bits are dropped on purpose.
    assign wdata_hi_unused = ^bus_wdata[REG_W-1:CNT_W];

    rxlen_classify #(
        .LEN_W      (LEN_W),
        .MAX_PLAIN  (MAX_PLAIN),
        .VLAN_EXTRA (VLAN_EXTRA),
        .MIN_LEN    (MIN_LEN)
    ) u_classify (
        .frm_end        (frm_end),
        .frm_len        (frm_len),
        .frm_vlan       (frm_vlan),
        .frm_fcs_ok     (frm_fcs_ok),
        .frm_dribble    (frm_dribble),
        .frm_wellformed (frm_wellformed),
        .inc_ovr        (inc_ovr),
        .inc_frg        (inc_frg)
    );

    // Place the increment requests in counter slot order.
    always_comb begin
        inc_vec           = '0;
        inc_vec[SLOT_OVR] = inc_ovr;
        inc_vec[SLOT_FRG] = inc_frg;
    end

    // One saturating counter per slot.
    for (genvar gc = 0; gc < NUM_CNT; gc++) begin : g_cnt
        rxlen_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_vec[gc]),
            .ld     (ld_vec[gc]),
            .ld_val (bus_wdata[CNT_W-1:0]),
            .cnt    (cnt_vec[gc])
        );
    end

    rxlen_regif #(
        .NUM_CNT     (NUM_CNT),
        .CNT_W       (CNT_W),
        .REG_W       (REG_W),
        .ADDR_W      (ADDR_W),
        .ADDR_STRIDE (ADDR_STRIDE)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .cnt_vec   (cnt_vec),
        .ld_vec    (ld_vec),
        .bus_rdata (bus_rdata)
    );

    // Named views of the counters, for the checker.
    assign cnt_ovr = cnt_vec[SLOT_OVR];
    assign cnt_frg = cnt_vec[SLOT_FRG];
endmodule

// File: rtl/rxlen_err_cnt_chk.sv
// Module: assertion checker for rxlen_err_cnt, attached with a bind.
// Watches the ports, the classifier requests and the counter state.
module rxlen_err_cnt_chk
    import rxlen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frm_end,
    input logic [LEN_W-1:0]  frm_len,
    input logic              frm_vlan,
    input logic              frm_fcs_ok,
    input logic              frm_dribble,
    input logic              frm_wellformed,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              inc_ovr,
    input logic              inc_frg,
    input logic [CNT_W-1:0]  cnt_ovr,
    input logic [CNT_W-1:0]  cnt_frg
);
    localparam logic [CNT_W-1:0] FULL = '1;

    AST_ONE_INC_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_ovr && inc_frg)); // R10

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_end && !bus_wr) |=> ($stable(cnt_ovr) && $stable(cnt_frg))); // R6

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_frg == FULL && !bus_wr) |=> (cnt_frg == FULL)); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (cnt_ovr == $past(bus_wdata[CNT_W-1:0]))); // R8

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W-1:CNT_W] == '0); // R7

    AST_UNTAGGED_LONG_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && !frm_vlan && frm_len > LEN_W'(MAX_PLAIN) && frm_fcs_ok
         && frm_wellformed && !frm_dribble && !bus_wr && cnt_ovr != FULL)
        |=> (cnt_ovr == CNT_W'($past(cnt_ovr) + 1'b1))); // R2

    AST_SHORT_BAD_FCS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && frm_len < LEN_W'(MIN_LEN) && !frm_fcs_ok && !bus_wr && cnt_frg != FULL)
        |=> (cnt_frg == CNT_W'($past(cnt_frg) + 1'b1))); // R5

    AST_DIRTY_LONG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && frm_len > LEN_W'(MIN_LEN) && (!frm_fcs_ok || !frm_wellformed || frm_dribble)
         && !bus_wr) |=> $stable(cnt_ovr)); // R4
endmodule

bind rxlen_err_cnt rxlen_err_cnt_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frm_end        (frm_end),
    .frm_len        (frm_len),
    .frm_vlan       (frm_vlan),
    .frm_fcs_ok     (frm_fcs_ok),
    .frm_dribble    (frm_dribble),
    .frm_wellformed (frm_wellformed),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .inc_ovr        (inc_ovr),
    .inc_frg        (inc_frg),
    .cnt_ovr        (cnt_ovr),
    .cnt_frg        (cnt_frg)
);

// File: tb/rxlen_err_cnt_tb.sv
module rxlen_err_cnt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_end = 1'b0;
    logic [15:0] frm_len = '0;
    logic        frm_vlan = 1'b0;
    logic        frm_fcs_ok = 1'b0;
    logic        frm_dribble = 1'b0;
    logic        frm_wellformed = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_ovr = '0;
    logic [15:0] exp_frg = '0;

    always #10 clk = ~clk;

    rxlen_err_cnt u_dut (
        .clk(clk), .rst_n(rst_n), .frm_end(frm_end), .frm_len(frm_len),
        .frm_vlan(frm_vlan), .frm_fcs_ok(frm_fcs_ok), .frm_dribble(frm_dribble),
        .frm_wellformed(frm_wellformed), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read: drive at a falling edge, capture at the rising edge, sample at the next falling edge.
    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic frame(input logic [15:0] len, input logic vl, input logic fcs,
                         input logic dr, input logic wf);
        frm_len = len; frm_vlan = vl; frm_fcs_ok = fcs; frm_dribble = dr;
        frm_wellformed = wf; frm_end = 1'b1;
        @(negedge clk);
        frm_end = 1'b0;
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev_o, prev_f, cur_o, cur_f;
        logic [15:0] lens [13];
        lens = '{16'd0, 16'd1, 16'd63, 16'd64, 16'd65, 16'd1517, 16'd1518,
                 16'd1519, 16'd1521, 16'd1522, 16'd1523, 16'd2000, 16'hFFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        rd(4'h0, d); check("R1 oversize reset", d, 32'h0);
        rd(4'h4, d); check("R1 fragment reset", d, 32'h0);
        prev_o = 32'h0; prev_f = 32'h0;

        // Sweep lengths around every threshold under all flag combinations.
        for (int li = 0; li < 13; li++) begin
            for (int f = 0; f < 16; f++) begin
                logic vl, fcs, dr, wf, lng, sht;
                string tag;
                vl = f[0]; fcs = f[1]; dr = f[2]; wf = f[3];
                frame(lens[li], vl, fcs, dr, wf);
                lng = (lens[li] > (vl ? 16'd1522 : 16'd1518));
                sht = (lens[li] < 16'd64);
                if (lng && fcs && wf && !dr && exp_ovr != 16'hFFFF) exp_ovr++;
                if (sht && !fcs && exp_frg != 16'hFFFF) exp_frg++;
                if (sht) tag = fcs ? "R6 short good fcs" : "R5 fragment";
                else if (lng) tag = (fcs && wf && !dr) ? (vl ? "R3 tagged long" : "R2 untagged long")
                                                        : "R4 unqualified long";
                else tag = (vl && lens[li] > 16'd1518) ? "R3 tagged within limit" : "R6 in range";
                rd(4'h0, cur_o); check({tag, " oversize"}, cur_o, {16'h0, exp_ovr});
                rd(4'h4, cur_f); check({tag, " fragment"}, cur_f, {16'h0, exp_frg});
                check("R10 one increment per frame",
                      32'(((cur_o - prev_o) + (cur_f - prev_f)) <= 32'd1), 32'd1);
                prev_o = cur_o; prev_f = cur_f;
            end
        end

        // Qualifying fields without the strobe change nothing.
        frm_len = 16'd2000; frm_fcs_ok = 1'b1; frm_wellformed = 1'b1; frm_dribble = 1'b0;
        repeat (3) @(negedge clk);
        frm_len = 16'd10; frm_fcs_ok = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'h0, d); check("R6 no strobe oversize", d, {16'h0, exp_ovr});
        rd(4'h4, d); check("R6 no strobe fragment", d, {16'h0, exp_frg});

        // Write in the same cycle as a qualifying oversize frame; upper bits ignored.
        bus_addr = 4'h0; bus_wdata = 32'hABCD_1234; bus_wr = 1'b1;
        frm_len = 16'd1600; frm_vlan = 1'b0; frm_fcs_ok = 1'b1; frm_dribble = 1'b0;
        frm_wellformed = 1'b1; frm_end = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frm_end = 1'b0;
        exp_ovr = 16'h1234;
        rd(4'h0, d); check("R8 write wins and upper bits dropped", d, 32'h0000_1234);

        // Write to an unmapped address, then read it back.
        wr(4'h8, 32'h0000_5555);
        rd(4'h0, d); check("R8 unmapped write oversize", d, {16'h0, exp_ovr});
        rd(4'h4, d); check("R8 unmapped write fragment", d, {16'h0, exp_frg});
        rd(4'h8, d); check("R7 unmapped read", d, 32'h0);

        // Read data holds while no read is requested.
        frame(16'd20, 1'b0, 1'b0, 1'b0, 1'b1);
        exp_frg++;
        check("R7 rdata holds without read", bus_rdata, 32'h0);

        // Saturation on both counters.
        wr(4'h4, 32'h0000_FFFE);
        frame(16'd30, 1'b1, 1'b0, 1'b1, 1'b0);
        rd(4'h4, d); check("R9 fragment reaches max", d, 32'h0000_FFFF);
        frame(16'd30, 1'b0, 1'b0, 1'b0, 1'b1);
        rd(4'h4, d); check("R9 fragment stays at max", d, 32'h0000_FFFF);
        wr(4'h0, 32'h0000_FFFF);
        frame(16'd1530, 1'b1, 1'b1, 1'b0, 1'b1);
        rd(4'h0, d); check("R9 oversize stays at max", d, 32'h0000_FFFF);
        wr(4'h4, 32'h0000_0000);
        rd(4'h4, d); check("R8 write clears fragment", d, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule